// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a virtual address to a physical address when a translation cache misses. It takes a 48-bit virtual address, the kind of access (load, store or instruction fetch) and whether the access comes from user mode. It then walks a four-level radix tree of 64-bit page table entries held in memory. The walk starts from a root table base supplied on an input port. Each level costs one entry read over a simple request/response memory port with one transaction outstanding.

At each level the walker checks the entry it has just read. The level-1 entry is checked first and the leaf is checked last. Write and user permission must hold at every level, and an execute-disable bit on any level blocks fetches. Together these give the combined permission of the whole path. If every level passes, the walker writes back the accessed bit on each entry that lacks it, and sets the dirty bit on the leaf for stores. It then reports the 52-bit physical address. A walk that fails ends with a fault code and the level at which it stopped, and it does not write to memory.

Top module: `pt_walker`

## Requirements
- R1: The virtual address splits into four 9-bit indices, most significant first, above a 12-bit offset. The level-1 entry address is {rootBase, va[47:39], 3'b000}. Each later level uses {entry[51:12] of the previous level, its index, 3'b000}. Entries are read in level order 1 to 4.
- R2: An entry with bit 0 (present) clear ends the walk with fault code 1 and the level of that entry. At one level the checks run in this priority: present (code 1), then page size (code 5), then write (code 2), then user (code 3), then execute (code 4).
- R3: A store (reqKind 1) ends with fault code 2 at the first level whose entry has bit 1 (writable) clear.
- R4: A user-mode access (reqUser 1) ends with fault code 3 at the first level whose entry has bit 2 (user-accessible) clear.
- R5: An instruction fetch (reqKind 2) ends with fault code 4 at the first level whose entry has bit 63 (no-execute) set. Loads use reqKind 0.
- R6: Bit 7 (large page) set in a level-1 entry ends the walk with fault code 5 at level 1. Bit 7 has no effect at levels 2 to 4.
- R7: A walk with no fault reports fault code 0, level 4, and donePaddr = {leaf entry[51:12], va[11:0]}. donePaddr is zero on any fault.
- R8: After all four levels pass, the walker writes each entry whose bit 5 (accessed) is clear, in level order. The data written is the entry with bit 5 set. For a store, the leaf is also written if its bit 6 (dirty) is clear, with both bits 5 and 6 set.
- R9: No write is issued for an entry that already holds the needed bits. A faulting walk issues no write at all.
- R10: reqReady is high only while idle. doneValid is a one-cycle pulse, after which reqReady is high again. memReqValid stays high with a stable address until memReqReady is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start a walk |
| reqReady | output | 1 | Walker idle, request accepted |
| reqVaddr | input | 48 | Virtual address to translate |
| reqKind | input | 2 | 0 load, 1 store, 2 fetch |
| reqUser | input | 1 | Access comes from user mode |
| rootBase | input | 40 | Page frame of the level-1 table |
| memReqValid | output | 1 | Memory request pending |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | Request is a write |
| memReqAddr | output | 52 | Byte address of the entry |
| memReqWdata | output | 64 | Entry value to write |
| memRespValid | input | 1 | Read data or write acknowledge |
| memRespData | input | 64 | Entry read from memory |
| doneValid | output | 1 | Walk finished (one cycle) |
| donePaddr | output | 52 | Translated physical address |
| doneFault | output | 3 | 0 none, 1 not present, 2 write, 3 user, 4 execute, 5 large page |
| doneLevel | output | 3 | Level 1 to 4 where the walk stopped |

## Verification
The assertions take for granted that the memory answers each accepted request exactly once, in order, and never raises memRespValid while nothing is outstanding. They also take for granted that a request is presented only while reqReady is high. The bench keeps to both rules. Its memory model holds a single pending transaction with a random 1 to 3 cycle latency and toggles memReqReady at random. Walks are launched one at a time, only after the previous done pulse.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int LEVELS        = 4;
  localparam int IDX_W         = 9;
  localparam int OFF_W         = 12;
  localparam int PPN_W         = 40;
  localparam int PTE_W         = 64;
  localparam int PTE_BYTES_LOG = 3;
  localparam int VA_W          = LEVELS * IDX_W + OFF_W;
  localparam int PA_W          = PPN_W + OFF_W;
  localparam int LVL_IDX_W     = $clog2(LEVELS);
  localparam int LVL_W         = $clog2(LEVELS + 1);

  // entry bit positions
  localparam int P_BIT  = 0;
  localparam int RW_BIT = 1;
  localparam int US_BIT = 2;
  localparam int A_BIT  = 5;
  localparam int D_BIT  = 6;
  localparam int PS_BIT = 7;
  localparam int XD_BIT = 63;

  localparam logic [1:0] KIND_READ  = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [2:0] FLT_NONE    = 3'd0;
  localparam logic [2:0] FLT_ABSENT  = 3'd1;
  localparam logic [2:0] FLT_WRITE   = 3'd2;
  localparam logic [2:0] FLT_USER    = 3'd3;
  localparam logic [2:0] FLT_EXEC    = 3'd4;
  localparam logic [2:0] FLT_BIGPAGE = 3'd5;

  typedef struct packed {
    logic latchReq;
    logic latchPte;
    logic wbAdvance;
    logic selWb;
  } ctlStrobes_t;

  typedef struct packed {
    logic walkFault;
    logic lastLevel;
    logic wbNeed;
    logic wbDone;
  } dpStatus_t;
endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memReqReady,
  input  logic        memRespValid,
  input  dpStatus_t   st,
  output ctlStrobes_t ctl,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        memReqWrite,
  output logic        doneValid
);
  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RDW, S_WBSCAN, S_WB, S_WBW, S_DONE
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState   = state;
    ctl         = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    doneValid   = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.latchReq = 1'b1;
          nextState    = S_RD;
        end
      end
      S_RD: begin
        memReqValid = 1'b1;
        if (memReqReady) nextState = S_RDW;
      end
      S_RDW: begin
        if (memRespValid) begin
          ctl.latchPte = 1'b1;
          if (st.walkFault)      nextState = S_DONE;
          else if (st.lastLevel) nextState = S_WBSCAN;
          else                   nextState = S_RD;
        end
      end
      S_WBSCAN: begin
        if (st.wbDone)      nextState = S_DONE;
        else if (st.wbNeed) nextState = S_WB;
        else                ctl.wbAdvance = 1'b1;
      end
      S_WB: begin
        ctl.selWb   = 1'b1;
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) nextState = S_WBW;
      end
      S_WBW: begin
        ctl.selWb = 1'b1;
        if (memRespValid) begin
          ctl.wbAdvance = 1'b1;
          nextState     = S_WBSCAN;
        end
      end
      S_DONE: begin
        doneValid = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && reqReady));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid);
endmodule

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  output dpStatus_t         st,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqKind,
  input  logic              reqUser,
  input  logic [PPN_W-1:0]  rootBase,
  input  logic [PTE_W-1:0]  memRespData,
  output logic [PA_W-1:0]   memReqAddr,
  output logic [PTE_W-1:0]  memReqWdata,
  output logic [PA_W-1:0]   donePaddr,
  output logic [2:0]        doneFault,
  output logic [LVL_W-1:0]  doneLevel
);
  logic [VA_W-1:0]      vaddrQ;
  logic [1:0]           kindQ;
  logic                 userQ;
  logic [LVL_IDX_W-1:0] lvlQ;
  logic [PPN_W-1:0]     baseQ;
  logic [PTE_W-1:0]     pteQ  [LEVELS];
  logic [PA_W-1:0]      addrQ [LEVELS];
  logic [LVL_W-1:0]     wbIdxQ;
  logic [2:0]           faultQ;

  logic [IDX_W-1:0]     curIdx;
  logic [PA_W-1:0]      readAddr;
  logic [2:0]           checkCode;
  logic [LVL_IDX_W-1:0] wbSel;
  logic [PTE_W-1:0]     wbPte;
  logic                 wbDirty;

  // index of the current level, most significant field first
  always_comb begin
    curIdx = vaddrQ[OFF_W + IDX_W * (LEVELS - 1 - int'(lvlQ)) +: IDX_W];
  end
  assign readAddr = {baseQ, curIdx, {PTE_BYTES_LOG{1'b0}}};

  // per-level entry check, priority encoded
  always_comb begin
    if (!memRespData[P_BIT])
      checkCode = FLT_ABSENT;
    else if (lvlQ == '0 && memRespData[PS_BIT])
      checkCode = FLT_BIGPAGE;
    else if (kindQ == KIND_WRITE && !memRespData[RW_BIT])
      checkCode = FLT_WRITE;
    else if (userQ && !memRespData[US_BIT])
      checkCode = FLT_USER;
    else if (kindQ == KIND_FETCH && memRespData[XD_BIT])
      checkCode = FLT_EXEC;
    else
      checkCode = FLT_NONE;
  end

  assign wbSel   = wbIdxQ[LVL_IDX_W-1:0];
  assign wbPte   = pteQ[wbSel];
  assign wbDirty = (wbSel == LVL_IDX_W'(LEVELS - 1)) && (kindQ == KIND_WRITE);

  always_comb begin
    st.walkFault = (checkCode != FLT_NONE);
    st.lastLevel = (lvlQ == LVL_IDX_W'(LEVELS - 1));
    st.wbDone    = (wbIdxQ == LVL_W'(LEVELS));
    st.wbNeed    = !st.wbDone && (!wbPte[A_BIT] || (wbDirty && !wbPte[D_BIT]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ <= '0;
      kindQ  <= KIND_READ;
      userQ  <= 1'b0;
      lvlQ   <= '0;
      baseQ  <= '0;
      wbIdxQ <= '0;
      faultQ <= FLT_NONE;
      for (int i = 0; i < LEVELS; i++) begin
        pteQ[i]  <= '0;
        addrQ[i] <= '0;
      end
    end else begin
      if (ctl.latchReq) begin
        vaddrQ <= reqVaddr;
        kindQ  <= reqKind;
        userQ  <= reqUser;
        lvlQ   <= '0;
        baseQ  <= rootBase;
        wbIdxQ <= '0;
        faultQ <= FLT_NONE;
      end
      if (ctl.latchPte) begin
        pteQ[lvlQ]  <= memRespData;
        addrQ[lvlQ] <= readAddr;
        if (st.walkFault) begin
          faultQ <= checkCode;
        end else if (!st.lastLevel) begin
          lvlQ  <= lvlQ + 1'b1;
          baseQ <= memRespData[OFF_W +: PPN_W];
        end
      end
      if (ctl.wbAdvance) wbIdxQ <= wbIdxQ + 1'b1;
    end
  end

  assign memReqAddr  = ctl.selWb ? addrQ[wbSel] : readAddr;
  assign memReqWdata = wbPte | (PTE_W'(1) << A_BIT) | (wbDirty ? (PTE_W'(1) << D_BIT) : '0);
  assign doneFault   = faultQ;
  assign doneLevel   = LVL_W'(lvlQ) + LVL_W'(1);
  assign donePaddr   = (faultQ == FLT_NONE) ?
                       {pteQ[LEVELS-1][OFF_W +: PPN_W], vaddrQ[OFF_W-1:0]} : '0;

  assert_level_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.latchPte && !st.walkFault && !st.lastLevel) |=> (lvlQ == $past(lvlQ) + 1'b1));

  assert_no_write_on_fault_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctl.selWb |-> (faultQ == FLT_NONE));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [1:0]        reqKind,
  input  logic              reqUser,
  input  logic [PPN_W-1:0]  rootBase,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [PA_W-1:0]   memReqAddr,
  output logic [PTE_W-1:0]  memReqWdata,
  input  logic              memRespValid,
  input  logic [PTE_W-1:0]  memRespData,
  output logic              doneValid,
  output logic [PA_W-1:0]   donePaddr,
  output logic [2:0]        doneFault,
  output logic [LVL_W-1:0]  doneLevel
);
  ctlStrobes_t ctl;
  dpStatus_t   st;

  ptw_ctrl u_ctrl (
    .clk, .rstN, .reqValid, .memReqReady, .memRespValid,
    .st, .ctl, .reqReady, .memReqValid, .memReqWrite, .doneValid
  );

  ptw_dpath u_dpath (
    .clk, .rstN, .ctl, .st, .reqVaddr, .reqKind, .reqUser, .rootBase,
    .memRespData, .memReqAddr, .memReqWdata, .donePaddr, .doneFault, .doneLevel
  );

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr) && $stable(memReqWrite)));

  assert_wdata_accessed_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> memReqWdata[A_BIT]);

  assert_fault_paddr_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneFault != FLT_NONE) |-> (donePaddr == '0));
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [47:0] reqVaddr = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0;
  logic [39:0] rootBase = 40'h00010;
  logic        memReqValid, memReqWrite;
  logic        memReqReady = 1'b0;
  logic [51:0] memReqAddr;
  logic [63:0] memReqWdata;
  logic        memRespValid = 1'b0;
  logic [63:0] memRespData = '0;
  logic        doneValid;
  logic [51:0] donePaddr;
  logic [2:0]  doneFault;
  logic [2:0]  doneLevel;

  pt_walker uut (.*);

  always #10 clk = ~clk;

  int compared = 0;
  int mismatched = 0;

  // memory model
  logic [63:0] mem [logic [51:0]];
  int          pendCnt = 0;
  logic [63:0] pendData;
  logic [51:0] obsRA [8];
  logic [51:0] obsWA [8];
  logic [63:0] obsWD [8];
  int          nObsR = 0, nObsW = 0;

  function automatic logic [63:0] rd(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  always @(posedge clk) begin
    memRespValid <= 1'b0;
    memReqReady  <= ($urandom % 2) == 0;
    if (pendCnt > 0) begin
      pendCnt <= pendCnt - 1;
      if (pendCnt == 1) begin
        memRespValid <= 1'b1;
        memRespData  <= pendData;
      end
    end else if (memReqValid && memReqReady) begin
      if (memReqWrite) begin
        mem[memReqAddr] = memReqWdata;
        if (nObsW < 8) begin obsWA[nObsW] = memReqAddr; obsWD[nObsW] = memReqWdata; end
        nObsW = nObsW + 1;
        pendData <= 64'h0;
      end else begin
        if (nObsR < 8) obsRA[nObsR] = memReqAddr;
        nObsR = nObsR + 1;
        pendData <= rd(memReqAddr);
      end
      pendCnt <= 1 + ($urandom % 3);
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // flag layout for builders: [6] xd, [5] large page, [4] dirty, [3] accessed, [2] user, [1] writable, [0] present
  function automatic logic [63:0] mkPte(input logic [6:0] f, input logic [39:0] base);
    return {f[6], 11'b0, base, 4'b0, f[5], f[4], f[3], 2'b0, f[2], f[1], f[0]};
  endfunction

  task automatic buildPath(input logic [47:0] va, input logic [6:0] f0, input logic [6:0] f1,
                           input logic [6:0] f2, input logic [6:0] f3,
                           input logic [39:0] b1, input logic [39:0] b2, input logic [39:0] b3,
                           input logic [39:0] ppn);
    mem.delete();
    mem[{rootBase, va[47:39], 3'b0}] = mkPte(f0, b1);
    mem[{b1, va[38:30], 3'b0}]       = mkPte(f1, b2);
    mem[{b2, va[29:21], 3'b0}]       = mkPte(f2, b3);
    mem[{b3, va[20:12], 3'b0}]       = mkPte(f3, ppn);
  endtask

  // expected results from the requirements
  logic [51:0] expRA [4];
  logic [51:0] expWA [4];
  logic [63:0] expWD [4];
  int          expNR, expNW;
  logic [2:0]  expCode, expLvl;
  logic [51:0] expPa;

  task automatic predict(input logic [47:0] va, input logic [1:0] kind, input logic user);
    logic [39:0] base;
    logic [63:0] pt [4];
    logic        stop;
    base = rootBase; expCode = 3'd0; expLvl = 3'd4; expNR = 0; expNW = 0; expPa = '0; stop = 1'b0;
    for (int l = 0; l < 4; l++) begin
      if (!stop) begin
        expRA[l] = {base, va[47 - 9*l -: 9], 3'b0};
        pt[l] = rd(expRA[l]);
        expNR = l + 1;
        if (!pt[l][0])                  expCode = 3'd1;
        else if (l == 0 && pt[l][7])    expCode = 3'd5;
        else if (kind == 2'd1 && !pt[l][1]) expCode = 3'd2;
        else if (user && !pt[l][2])     expCode = 3'd3;
        else if (kind == 2'd2 && pt[l][63]) expCode = 3'd4;
        if (expCode != 3'd0) begin stop = 1'b1; expLvl = 3'(l + 1); end
        base = pt[l][51:12];
      end
    end
    if (!stop) begin
      expPa = {pt[3][51:12], va[11:0]};
      for (int l = 0; l < 4; l++) begin
        logic dirt;
        dirt = (l == 3) && (kind == 2'd1);
        if (!pt[l][5] || (dirt && !pt[l][6])) begin
          expWA[expNW] = expRA[l];
          expWD[expNW] = pt[l] | 64'h20 | (dirt ? 64'h40 : 64'h0);
          expNW++;
        end
      end
    end
  endtask

  function automatic string codeTag(input logic [2:0] c);
    case (c)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic runWalk(input logic [47:0] va, input logic [1:0] kind, input logic user);
    int waitCnt;
    predict(va, kind, user);
    nObsR = 0; nObsW = 0;
    @(negedge clk);
    chk("R10 ready when idle", reqReady, 1);
    reqValid = 1'b1; reqVaddr = va; reqKind = kind; reqUser = user;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R10 busy after accept", reqReady, 0);
    waitCnt = 0;
    while (!doneValid && waitCnt < 400) begin @(negedge clk); waitCnt++; end
    chk("R10 walk completes", doneValid, 1);
    chk({codeTag(expCode), " fault code"}, doneFault, expCode);
    chk({codeTag(expCode), " fault level"}, doneLevel, expLvl);
    chk("R7 physical address", donePaddr, expPa);
    chk("R1 read count", nObsR, expNR);
    for (int i = 0; i < expNR && i < nObsR; i++) chk("R1 entry read address", obsRA[i], expRA[i]);
    chk("R9 write count", nObsW, expNW);
    for (int i = 0; i < expNW && i < nObsW; i++) begin
      chk("R8 write address", obsWA[i], expWA[i]);
      chk("R8 write data", obsWD[i], expWD[i]);
    end
    @(negedge clk);
    chk("R10 done is one pulse", doneValid, 0);
    chk("R10 idle after done", reqReady, 1);
  endtask

  localparam logic [6:0] OK  = 7'b0011111;  // present, writable, user, accessed, dirty
  localparam logic [6:0] NOA = 7'b0000111;  // accessed and dirty clear

  initial begin
    repeat (160000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [47:0] va;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // reset state
    chk("R10 reset idle ready", reqReady, 1);
    chk("R10 reset no request", memReqValid, 0);
    chk("R10 reset no done", doneValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    va = 48'h1234_5678_9ABC;
    // R7/R9: load, all bits already set, no writes
    buildPath(va, OK, OK, OK, OK, 40'h00200, 40'h00300, 40'h00400, 40'hABCDE);
    runWalk(va, 2'd0, 1'b1);
    // R8: store with accessed/dirty clear everywhere
    buildPath(va, NOA, NOA, NOA, NOA, 40'h00200, 40'h00300, 40'h00400, 40'h13579);
    runWalk(va, 2'd1, 1'b0);
    // R8: load with accessed clear, dirty untouched
    buildPath(va, NOA, OK, NOA, NOA, 40'h00200, 40'h00300, 40'h00400, 40'h13579);
    runWalk(va, 2'd0, 1'b0);
    // R2: level 2 not present, no writes
    buildPath(va, NOA, 7'b0011110, OK, OK, 40'h00200, 40'h00300, 40'h00400, 40'h1);
    runWalk(va, 2'd0, 1'b0);
    // R2 priority: absent beats write-protect at level 1
    buildPath(va, 7'b0011100, OK, OK, OK, 40'h00200, 40'h00300, 40'h00400, 40'h1);
    runWalk(va, 2'd1, 1'b0);
    // R3: write-protect at level 3
    buildPath(va, NOA, NOA, 7'b0011101, NOA, 40'h00200, 40'h00300, 40'h00400, 40'h2);
    runWalk(va, 2'd1, 1'b0);
    // R3: read through read-only path succeeds
    runWalk(va, 2'd0, 1'b0);
    // R4: user-protect at level 1
    buildPath(va, 7'b0011011, OK, OK, OK, 40'h00200, 40'h00300, 40'h00400, 40'h3);
    runWalk(va, 2'd0, 1'b1);
    // R5: fetch with no-execute at level 4
    buildPath(va, OK, OK, OK, 7'b1011111, 40'h00200, 40'h00300, 40'h00400, 40'h4);
    runWalk(va, 2'd2, 1'b0);
    runWalk(va, 2'd0, 1'b0);
    // R6: large page at level 1
    buildPath(va, 7'b0111111, OK, OK, OK, 40'h00200, 40'h00300, 40'h00400, 40'h5);
    runWalk(va, 2'd0, 1'b0);
    // R6: large-page bit at level 3 ignored
    buildPath(va, OK, OK, 7'b0111111, OK, 40'h00200, 40'h00300, 40'h00400, 40'h6);
    runWalk(va, 2'd0, 1'b0);

    for (int n = 0; n < 250; n++) begin
      logic [6:0] f [4];
      logic [47:0] rva;
      rva = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
      for (int l = 0; l < 4; l++) begin
        f[l][0] = ($urandom % 16) != 0;
        f[l][1] = ($urandom % 4) != 0;
        f[l][2] = ($urandom % 4) != 0;
        f[l][3] = ($urandom % 2) != 0;
        f[l][4] = ($urandom % 2) != 0;
        f[l][5] = ($urandom % 8) == 0;
        f[l][6] = ($urandom % 8) == 0;
      end
      buildPath(rva, f[0], f[1], f[2], f[3],
                {28'h1, 12'($urandom)}, {28'h2, 12'($urandom)}, {28'h3, 12'($urandom)},
                40'($urandom));
      runWalk(rva, 2'($urandom % 3), 1'($urandom % 2));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule